// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers interrupt events from a bank of DMA channels (16 by default) and turns them into one level-sensitive interrupt line for the processor. Each channel can report four kinds of event: completion of a whole descriptor chain, completion of a flagged descriptor node, and two independent error kinds. The events arrive as single-cycle pulses on four per-channel input vectors, one vector per kind. Bit i of each vector belongs to channel i.

For every kind the block keeps a sticky raw latch and an enable mask. A raw bit sets on its event whatever the mask holds. The masked view of a kind is its raw latches ANDed with its mask. A per-channel summary word ORs the four masked views, and the interrupt line is high while any summary bit is set. Software reads the registers over a simple request/acknowledge bus and clears raw bits by writing ones to them. To stop a channel, software writes that channel's one-hot value to all four raw registers, which removes every event pending for that channel.

The bus side is a two-state machine. In `BUS_IDLE`, a request moves it to `BUS_RESP` (transition IDLE_TO_RESP). In that cycle the write takes effect and the read data are captured. `BUS_RESP` always returns to `BUS_IDLE` on the next clock (transition RESP_TO_IDLE), and the acknowledge is high during it. Register offsets: summary 0x000; masked views 0x004 (chain), 0x008 (node), 0x00C (error A), 0x010 (error B); masks 0x018, 0x01C, 0x020, 0x024 in the same kind order; raw latches 0x600, 0x608, 0x610, 0x618 in the same kind order.

Top module: `irq_aggregator`

## Requirements
- R1: After reset all raw latches and all masks are zero, the interrupt line is low and the acknowledge is low.
- R2: An event pulse sets the raw bit of its kind and channel (readable at 0x600/0x608/0x610/0x618) even when that kind's mask bit is 0.
- R3: The masked view of a kind (0x004/0x008/0x00C/0x010) reads as its raw bits ANDed with its mask bits.
- R4: The summary word at 0x000 has bit i set exactly when any of the four masked views has bit i set.
- R5: The interrupt line is high while any summary bit is set, and it stays high until every enabled pending bit is cleared.
- R6: Writing a raw register clears each bit written as 1, and bits written as 0 keep their value.
- R7: If an event and a write-one-to-clear hit the same raw bit in the same cycle, the bit ends up set.
- R8: A mask write (0x018/0x01C/0x020/0x024) stores the low channel bits: 1 enables a channel and 0 blocks it. The mask reads back as written and changes on no other occasion.
- R9: Writing a one-hot channel value to all four raw registers clears that channel's pending events in every kind and leaves the other channels untouched.
- R10: The acknowledge is high for exactly the one cycle after an accepted request, and read data are valid in that cycle. A request presented while the acknowledge is high is ignored.
- R11: Writes to the summary word, the masked views or unmapped offsets change nothing. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chain_done_i | input | NUM_CH | Chain-complete event pulses, one bit per channel |
| node_done_i | input | NUM_CH | Node-complete event pulses, one bit per channel |
| fault_a_i | input | NUM_CH | Error kind A pulses, one bit per channel |
| fault_b_i | input | NUM_CH | Error kind B pulses, one bit per channel |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid while acknowledge is high |
| bus_ack_o | output | 1 | Access acknowledge, one cycle |
| irq_o | output | 1 | Level interrupt to the processor |

## Verification
The checker watches every cycle for the acknowledge timing, for every event pulse showing up in its raw latch one cycle later, for raw latches and masks that stay still when neither an event nor an accepted write is present, and for the interrupt line being high whenever an enabled raw bit is pending. The scenarios cover what only register values can show. These are the exact readback of masked views and the summary, selective clearing by ones versus zeros, an event and a clear landing on the same bit, stopping one channel across all four kinds, a request held into the acknowledge cycle, and writes to read-only and unmapped offsets.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int NUM_CLASSES = 4;

    // Event kinds; the index is the order of the per-kind register blocks.
    typedef enum logic [1:0] {
        CLS_CHAIN   = 2'd0,
        CLS_NODE    = 2'd1,
        CLS_FAULT_A = 2'd2,
        CLS_FAULT_B = 2'd3
    } irq_class_e;

    // Register offsets and strides between kinds.
    localparam int OFS_SUMMARY     = 'h000;
    localparam int OFS_MASKED_BASE = 'h004;
    localparam int OFS_MASKED_STEP = 4;
    localparam int OFS_ENABLE_BASE = 'h018;
    localparam int OFS_ENABLE_STEP = 4;
    localparam int OFS_RAW_BASE    = 'h600;
    localparam int OFS_RAW_STEP    = 8;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_SUMMARY,
        REG_MASKED,
        REG_ENABLE,
        REG_RAW
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [1:0] cls;
    } reg_sel_t;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_RESP = 2'd1
    } bus_state_e;

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_t          sel_o
);

    always_comb begin
        sel_o = '{kind: REG_NONE, cls: 2'd0};
        if (addr_i == ADDR_W'(OFS_SUMMARY)) begin
            sel_o.kind = REG_SUMMARY;
        end
        for (int k = 0; k < NUM_CLASSES; k++) begin
            if (addr_i == ADDR_W'(OFS_MASKED_BASE + k * OFS_MASKED_STEP)) begin
                sel_o.kind = REG_MASKED;
                sel_o.cls  = 2'(k);
            end
            if (addr_i == ADDR_W'(OFS_ENABLE_BASE + k * OFS_ENABLE_STEP)) begin
                sel_o.kind = REG_ENABLE;
                sel_o.cls  = 2'(k);
            end
            if (addr_i == ADDR_W'(OFS_RAW_BASE + k * OFS_RAW_STEP)) begin
                sel_o.kind = REG_RAW;
                sel_o.cls  = 2'(k);
            end
        end
    end

endmodule

// File: rtl/irq_class_bank.sv
module irq_class_bank #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt_i,
    input  logic              en_wr_i,
    input  logic              clr_wr_i,
    input  logic [NUM_CH-1:0] wdata_i,
    output logic [NUM_CH-1:0] raw_o,
    output logic [NUM_CH-1:0] enable_o,
    output logic [NUM_CH-1:0] masked_o
);

    logic [NUM_CH-1:0] raw_q;
    logic [NUM_CH-1:0] enable_q;
    logic [NUM_CH-1:0] clr_bits;

    assign clr_bits = clr_wr_i ? wdata_i : '0;

    // Sticky latch: set term applied after the clear, so a new event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_bits) | evt_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (en_wr_i) begin
            enable_q <= wdata_i;
        end
    end

    assign raw_o    = raw_q;
    assign enable_o = enable_q;
    assign masked_o = raw_q & enable_q;

endmodule

// File: rtl/irq_bus_fsm.sv
module irq_bus_fsm
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int NUM_CH = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req_i,
    input  logic                                we_i,
    input  logic [ADDR_W-1:0]                   addr_i,
    input  logic [DATA_W-1:0]                   wdata_i,
    input  logic [NUM_CH-1:0]                   summary_i,
    input  logic [NUM_CLASSES-1:0][NUM_CH-1:0]  masked_i,
    input  logic [NUM_CLASSES-1:0][NUM_CH-1:0]  enable_i,
    input  logic [NUM_CLASSES-1:0][NUM_CH-1:0]  raw_i,
    output logic [NUM_CLASSES-1:0]              en_wr_o,
    output logic [NUM_CLASSES-1:0]              clr_wr_o,
    output logic [NUM_CH-1:0]                   wr_bits_o,
    output logic [DATA_W-1:0]                   rdata_o,
    output logic                                ack_o
);

    bus_state_e        state_q;
    bus_state_e        state_d;
    reg_sel_t          sel;
    logic              accept;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    irq_addr_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr_i (addr_i),
        .sel_o  (sel)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (req_i) state_d = BUS_RESP;
            BUS_RESP: state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs and strobes.
    always_comb begin
        accept   = 1'b0;
        ack_o    = 1'b0;
        en_wr_o  = '0;
        clr_wr_o = '0;
        unique case (state_q)
            BUS_IDLE: begin
                accept = req_i;
                for (int k = 0; k < NUM_CLASSES; k++) begin
                    en_wr_o[k]  = req_i && we_i && (sel.kind == REG_ENABLE) && (sel.cls == 2'(k));
                    clr_wr_o[k] = req_i && we_i && (sel.kind == REG_RAW)    && (sel.cls == 2'(k));
                end
            end
            BUS_RESP: ack_o = 1'b1;
            default:  ack_o = 1'b0;
        endcase
    end

    assign wr_bits_o = wdata_i[NUM_CH-1:0];

    generate
        if (DATA_W > NUM_CH) begin : g_spare_bits
            logic spare_unused;
            assign spare_unused = ^wdata_i[DATA_W-1:NUM_CH];
        end
    endgenerate

    // Read multiplexer.
    always_comb begin
        rd_mux = '0;
        unique case (sel.kind)
            REG_SUMMARY: rd_mux = DATA_W'(summary_i);
            REG_MASKED:  rd_mux = DATA_W'(masked_i[sel.cls]);
            REG_ENABLE:  rd_mux = DATA_W'(enable_i[sel.cls]);
            REG_RAW:     rd_mux = DATA_W'(raw_i[sel.cls]);
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (accept && !we_i) begin
            rdata_q <= rd_mux;
        end else if (accept) begin
            rdata_q <= '0;
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chain_done_i,
    input  logic [NUM_CH-1:0] node_done_i,
    input  logic [NUM_CH-1:0] fault_a_i,
    input  logic [NUM_CH-1:0] fault_b_i,
    input  logic              bus_req_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              bus_ack_o,
    output logic              irq_o
);

    logic [NUM_CLASSES-1:0][NUM_CH-1:0] evt_vec;
    logic [NUM_CLASSES-1:0][NUM_CH-1:0] raw_q;
    logic [NUM_CLASSES-1:0][NUM_CH-1:0] enable_q;
    logic [NUM_CLASSES-1:0][NUM_CH-1:0] masked_w;
    logic [NUM_CLASSES-1:0]             en_wr;
    logic [NUM_CLASSES-1:0]             clr_wr;
    logic [NUM_CH-1:0]                  wr_bits;
    logic [NUM_CH-1:0]                  summary;

    assign evt_vec[CLS_CHAIN]   = chain_done_i;
    assign evt_vec[CLS_NODE]    = node_done_i;
    assign evt_vec[CLS_FAULT_A] = fault_a_i;
    assign evt_vec[CLS_FAULT_B] = fault_b_i;

    generate
        for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_bank
            irq_class_bank #(.NUM_CH(NUM_CH)) bank_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .evt_i    (evt_vec[c]),
                .en_wr_i  (en_wr[c]),
                .clr_wr_i (clr_wr[c]),
                .wdata_i  (wr_bits),
                .raw_o    (raw_q[c]),
                .enable_o (enable_q[c]),
                .masked_o (masked_w[c])
            );
        end
    endgenerate

    always_comb begin
        summary = '0;
        for (int c = 0; c < NUM_CLASSES; c++) begin
            summary = summary | masked_w[c];
        end
    end

    assign irq_o = |summary;

    irq_bus_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NUM_CH (NUM_CH)
    ) bus_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (bus_req_i),
        .we_i      (bus_we_i),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .summary_i (summary),
        .masked_i  (masked_w),
        .enable_i  (enable_q),
        .raw_i     (raw_q),
        .en_wr_o   (en_wr),
        .clr_wr_o  (clr_wr),
        .wr_bits_o (wr_bits),
        .rdata_o   (bus_rdata_o),
        .ack_o     (bus_ack_o)
    );

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
    parameter int NUM_CH = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [4*NUM_CH-1:0] evt_all,
    input logic [4*NUM_CH-1:0] raw_all,
    input logic [4*NUM_CH-1:0] enable_all,
    input logic                bus_req,
    input logic                bus_we,
    input logic                bus_ack,
    input logic                irq
);

    p_ack_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> bus_ack);

    p_ack_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    p_event_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_all) |=> ((raw_all & $past(evt_all)) == $past(evt_all)));

    p_raw_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|evt_all) && !(bus_req && bus_we && !bus_ack)) |=> $stable(raw_all));

    p_mask_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && bus_we && !bus_ack) |=> $stable(enable_all));

    p_irq_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(raw_all & enable_all)) |-> irq);

endmodule

bind irq_aggregator irq_aggregator_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_all    (evt_vec),
    .raw_all    (raw_q),
    .enable_all (enable_q),
    .bus_req    (bus_req_i),
    .bus_we     (bus_we_i),
    .bus_ack    (bus_ack_o),
    .irq        (irq_o)
);

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;

    localparam int NUM_CH = 16;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] chain_done = '0;
    logic [NUM_CH-1:0] node_done = '0;
    logic [NUM_CH-1:0] fault_a = '0;
    logic [NUM_CH-1:0] fault_b = '0;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              bus_ack;
    logic              irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    irq_aggregator #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .chain_done_i (chain_done),
        .node_done_i  (node_done),
        .fault_a_i    (fault_a),
        .fault_b_i    (fault_b),
        .bus_req_i    (bus_req),
        .bus_we_i     (bus_we),
        .bus_addr_i   (bus_addr),
        .bus_wdata_i  (bus_wdata),
        .bus_rdata_o  (bus_rdata),
        .bus_ack_o    (bus_ack),
        .irq_o        (irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        check(act === exp, tag, act, exp);
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
        @(negedge clk);
    endtask

    task automatic read_expect(input string tag, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check_eq(tag, d, exp);
    endtask

    task automatic pulse(input int cls, input logic [NUM_CH-1:0] v);
        @(negedge clk);
        case (cls)
            0: chain_done = v;
            1: node_done  = v;
            2: fault_a    = v;
            default: fault_b = v;
        endcase
        @(negedge clk);
        chain_done = '0; node_done = '0; fault_a = '0; fault_b = '0;
    endtask

    task automatic t_reset_r1();
        check_eq("R1 irq after reset", {31'd0, irq}, 32'd0);
        check_eq("R1 ack after reset", {31'd0, bus_ack}, 32'd0);
        read_expect("R1 raw chain", 12'h600, 32'h0);
        read_expect("R1 raw node", 12'h608, 32'h0);
        read_expect("R1 raw fault A", 12'h610, 32'h0);
        read_expect("R1 raw fault B", 12'h618, 32'h0);
        read_expect("R1 mask chain", 12'h018, 32'h0);
        read_expect("R1 mask fault B", 12'h024, 32'h0);
        read_expect("R1 summary", 12'h000, 32'h0);
    endtask

    task automatic t_raw_unmasked_r2();
        pulse(0, 16'h0008);
        read_expect("R2 raw chain set while masked", 12'h600, 32'h0008);
        check_eq("R2 irq blocked by mask", {31'd0, irq}, 32'd0);
        read_expect("R2 masked chain zero", 12'h004, 32'h0);
        read_expect("R2 summary zero", 12'h000, 32'h0);
    endtask

    task automatic t_mask_enable_r8();
        bus_write(12'h018, 32'h0000_FFFF);
        read_expect("R8 mask readback", 12'h018, 32'h0000_FFFF);
        check_eq("R5 irq high after enable", {31'd0, irq}, 32'd1);
        read_expect("R3 masked chain", 12'h004, 32'h0008);
        read_expect("R4 summary chain only", 12'h000, 32'h0008);
    endtask

    task automatic t_summary_merge_r4();
        bus_write(12'h024, 32'h0000_0020);
        pulse(3, 16'h0020);
        pulse(1, 16'h0200);
        read_expect("R4 summary merges kinds", 12'h000, 32'h0028);
        read_expect("R2 raw node", 12'h608, 32'h0200);
        read_expect("R3 masked node blocked", 12'h008, 32'h0);
        read_expect("R3 masked fault B", 12'h010, 32'h0020);
    endtask

    task automatic t_w1c_r6();
        bus_write(12'h600, 32'h0);
        read_expect("R6 zero write keeps bit", 12'h600, 32'h0008);
        bus_write(12'h600, 32'h0008);
        read_expect("R6 one write clears bit", 12'h600, 32'h0);
        check_eq("R5 irq held by fault B", {31'd0, irq}, 32'd1);
        bus_write(12'h618, 32'h0020);
        check_eq("R5 irq low after last clear", {31'd0, irq}, 32'd0);
        read_expect("R6 other kind untouched", 12'h608, 32'h0200);
    endtask

    task automatic t_stop_channel_r9();
        pulse(0, 16'h0084);
        pulse(1, 16'h0084);
        pulse(2, 16'h0084);
        pulse(3, 16'h0084);
        bus_write(12'h600, 32'h0004);
        bus_write(12'h608, 32'h0004);
        bus_write(12'h610, 32'h0004);
        bus_write(12'h618, 32'h0004);
        read_expect("R9 chain after stop", 12'h600, 32'h0080);
        read_expect("R9 node after stop", 12'h608, 32'h0280);
        read_expect("R9 fault A after stop", 12'h610, 32'h0080);
        read_expect("R9 fault B after stop", 12'h618, 32'h0080);
    endtask

    task automatic t_collision_r7();
        bus_write(12'h020, 32'h0000_FFFF);
        pulse(2, 16'h0800);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'h610; bus_wdata = 32'h0000_0880;
        fault_a = 16'h0800;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; fault_a = '0;
        @(negedge clk);
        read_expect("R7 event beats clear", 12'h610, 32'h0800);
        read_expect("R4 summary after collision", 12'h000, 32'h0880);
    endtask

    task automatic t_ignored_r10();
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'h01C; bus_wdata = 32'h0000_0001;
        @(negedge clk);
        check_eq("R10 ack one cycle after request", {31'd0, bus_ack}, 32'd1);
        bus_wdata = 32'h0000_FFFF;
        @(negedge clk);
        check_eq("R10 ack drops after one cycle", {31'd0, bus_ack}, 32'd0);
        bus_req = 1'b0; bus_we = 1'b0;
        @(negedge clk);
        read_expect("R10 request during ack ignored", 12'h01C, 32'h0001);
    endtask

    task automatic t_readonly_r11();
        bus_write(12'h000, 32'h0000_FFFF);
        bus_write(12'h004, 32'h0);
        bus_write(12'h100, 32'h0000_FFFF);
        read_expect("R11 masked chain unchanged", 12'h004, 32'h0080);
        read_expect("R11 summary unchanged", 12'h000, 32'h0880);
        read_expect("R11 unmapped reads zero", 12'h100, 32'h0);
        read_expect("R11 gap reads zero", 12'h014, 32'h0);
        read_expect("R11 raw chain unchanged", 12'h600, 32'h0080);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_raw_unmasked_r2();
        t_mask_enable_r8();
        t_summary_merge_r4();
        t_w1c_r6();
        t_stop_channel_r9();
        t_collision_r7();
        t_ignored_r10();
        t_readonly_r11();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

endmodule